// File: doc/BRIEF.md
# Instruction Boundary Extractor

This block sits after the instruction cache in the front end of a machine whose instructions are a variable number of bytes long. Every cached byte comes with one predecode flag that is set when that byte is the final byte of an instruction. The block receives one naturally aligned 16-byte fetch chunk per cycle, with its 16 flags and an entry offset. Without decoding any opcode, it reports where each complete instruction in the chunk starts and how long it is. Up to four instructions are reported per cycle, lowest byte first.

Bytes that follow the last flagged byte belong to an instruction that continues into the next chunk. The block keeps those bytes and presents them ahead of the next sequential chunk, and it adds their count to the length of the first instruction found there. A chunk reached by a taken branch starts at the entry offset and drops any carried bytes. If the branch lands inside what the flags describe as the body of an instruction, the block rejects the chunk and asks for the lengths to be verified. If a chunk holds more instructions than fit in one cycle, the block tells the fetch stage to present the chunk again from the first byte it did not report.

The outputs are combinational from the current chunk and the carried state. The carried state changes only on clock edges where a chunk is valid.

Top module: `ibx_extract`

## Requirements
- R1: After a synchronous reset the block holds no carried bytes. The first sequential chunk after reset shows `pre_cnt` = 0.
- R2: For a valid, accepted chunk, the first instruction starts at the scan base. Each later instruction starts at the byte just after a set flag, and each instruction ends at a set flag. At most 4 are reported, in ascending byte order: slot k uses `slot_vld[k]`, `slot_start[4k+3:4k]` and `slot_len[5k+4:5k]`, and the valid slots are the lowest ones.
- R3: When `redirect` is 1, the scan base is `entry_ofs` and flags below it are ignored. When `redirect` is 0, the scan base is byte 0 and `entry_ofs` has no effect. An entry at byte 15 with flag 14 set gives at most one one-byte instruction.
- R4: When `redirect` is 1, `entry_ofs` is not 0 and the flag of byte `entry_ofs`-1 is clear, `entry_bad` is 1, no slot and no `refetch` is reported, and the carried bytes are discarded. A redirect to byte 0 never raises `entry_bad`.
- R5: When the chunk is accepted without refetch and has at least one end flag at or above the scan base, the bytes after the last end flag are carried. On the next valid sequential chunk, `pre_cnt` shows their count, `pre_data[8i+7:8i]` shows carried byte i (oldest first), and slot 0's length includes `pre_cnt`.
- R6: A redirected chunk with no end flag at or above the entry offset reports no slot and carries every byte from the entry offset to byte 15.
- R7: If the new carried total would exceed 15 bytes, `len_overrun` is 1 for that cycle and the carried bytes are discarded. A sequential chunk with no end flag always causes this.
- R8: When `redirect` is 1, `pre_cnt` is 0 and carried bytes do not add to any length.
- R9: When more than 4 end flags lie at or above the scan base, `refetch` is 1 and `refetch_ofs` is the byte after the fourth reported instruction. All 4 slots are valid, and the carried bytes are discarded.
- R10: When `chunk_vld` is 0, no slot, `entry_bad`, `len_overrun` or `refetch` is raised, `pre_cnt` reads 0, and the carried bytes are kept for the next valid chunk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chunk_vld | input | 1 | A fetch chunk is present this cycle |
| chunk_data | input | 128 | Chunk bytes, byte i at bits 8i+7:8i |
| chunk_mark | input | 16 | End-of-instruction flag per byte |
| entry_ofs | input | 4 | Entry byte for a redirected chunk |
| redirect | input | 1 | Chunk was reached by a taken branch or refetch |
| slot_vld | output | 4 | Valid flag per reported instruction |
| slot_start | output | 16 | Start byte per slot, 4 bits each |
| slot_len | output | 20 | Length in bytes per slot, 5 bits each |
| pre_cnt | output | 4 | Number of carried bytes joined to this chunk |
| pre_data | output | 120 | Carried bytes, oldest at bits 7:0 |
| entry_bad | output | 1 | Entry offset disagrees with the flags; lengths must be verified |
| len_overrun | output | 1 | Carried partial instruction grew beyond 15 bytes |
| refetch | output | 1 | Chunk holds more instructions than one cycle reports |
| refetch_ofs | output | 4 | Byte at which to present the chunk again |

## Verification
The assertions assume that `redirect` and `entry_ofs` are meaningful only while `chunk_vld` is high. They also assume that the flag vector is exactly what the cache delivers, so a redirect to a mid-chunk byte may or may not agree with it. The stimulus builds flag vectors by walking random instruction lengths from a random first end. It mixes sequential and redirected chunks at random offsets and inserts idle cycles. It also drives directed cases: a last-byte entry, a mid-instruction entry, runs of bytes with no flag, and all-flags chunks re-presented at the refetch offset.

// File: rtl/ibx_pkg.sv
package ibx_pkg;

    localparam int CHUNK_BYTES = 16;
    localparam int NSLOT       = 4;
    localparam int MAX_LEN     = 15;

    localparam int OFS_W = $clog2(CHUNK_BYTES);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int LEN_W = $clog2(CHUNK_BYTES + MAX_LEN + 1);

    typedef logic [OFS_W-1:0]         ofs_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic [LEN_W-1:0]         len_t;
    typedef logic [CHUNK_BYTES-1:0]   mark_t;

    typedef struct packed {
        logic vld;
        ofs_t start;
        len_t len;
    } slot_t;

    typedef enum logic [1:0] {
        CARRY_KEEP,
        CARRY_CLEAR,
        CARRY_LOAD
    } carry_op_e;

    // lowest set position of a flag vector (0 when empty)
    function automatic ofs_t first_one(input mark_t v);
        ofs_t r;
        r = '0;
        for (int i = CHUNK_BYTES - 1; i >= 0; i--) begin
            if (v[i]) r = ofs_t'(i);
        end
        return r;
    endfunction

    // highest set position of a flag vector (0 when empty)
    function automatic ofs_t last_one(input mark_t v);
        ofs_t r;
        r = '0;
        for (int i = 0; i < CHUNK_BYTES; i++) begin
            if (v[i]) r = ofs_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ibx_end_scan.sv
module ibx_end_scan
    import ibx_pkg::*;
(
    input  ofs_t                 base,
    input  mark_t                mark,
    output logic [NSLOT-1:0]     hit,
    output ofs_t [NSLOT-1:0]     pos,
    output logic                 more,
    output logic                 any_end,
    output ofs_t                 last_end
);

    mark_t window;
    mark_t rem [NSLOT+1];

    // flags below the scan base are invisible
    assign window = mark & ({CHUNK_BYTES{1'b1}} << base);
    assign rem[0] = window;

    for (genvar k = 0; k < NSLOT; k++) begin : g_pick
        assign hit[k]    = |rem[k];
        assign pos[k]    = first_one(rem[k]);
        // strip the lowest set flag for the following slot
        assign rem[k+1]  = rem[k] & (rem[k] - 1'b1);
    end

    assign more     = |rem[NSLOT];
    assign any_end  = |window;
    assign last_end = last_one(window);

endmodule

// File: rtl/ibx_entry_chk.sv
module ibx_entry_chk
    import ibx_pkg::*;
(
    input  logic  redirect,
    input  ofs_t  entry,
    input  mark_t mark,
    output logic  bad
);

    ofs_t prev_byte;

    assign prev_byte = entry - 1'b1;

    always_comb begin
        bad = 1'b0;
        // a branch target at byte 0 cannot be checked: the preceding
        // chunk's flags are not at hand
        if (redirect && (entry != '0)) begin
            bad = !mark[prev_byte];
        end
    end

endmodule

// File: rtl/ibx_carry_buf.sv
module ibx_carry_buf
    import ibx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  carry_op_e                   op,
    input  cnt_t                        keep_cnt,
    input  len_t                        tail,
    input  logic [CHUNK_BYTES*8-1:0]    chunk,
    output cnt_t                        cnt,
    output logic [MAX_LEN*8-1:0]        data,
    output logic                        overrun
);

    len_t                   total;
    logic [MAX_LEN*8-1:0]   nxt;

    // retained old bytes plus bytes from tail to the chunk end
    assign total   = len_t'(keep_cnt) + (len_t'(CHUNK_BYTES) - tail);
    assign overrun = (op == CARRY_LOAD) && (total > len_t'(MAX_LEN));

    always_comb begin
        nxt = '0;
        for (int j = 0; j < MAX_LEN; j++) begin
            int src;
            src = j - int'(keep_cnt) + int'(tail);
            if (j < int'(keep_cnt)) begin
                nxt[j*8 +: 8] = data[j*8 +: 8];
            end else if (src < CHUNK_BYTES) begin
                nxt[j*8 +: 8] = chunk[src*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            data <= '0;
        end else begin
            case (op)
                CARRY_CLEAR: cnt <= '0;
                CARRY_LOAD: begin
                    if (overrun) begin
                        cnt <= '0;
                    end else begin
                        cnt  <= cnt_t'(total);
                        data <= nxt;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ibx_extract.sv
module ibx_extract
    import ibx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chunk_vld,
    input  logic [CHUNK_BYTES*8-1:0]    chunk_data,
    input  logic [CHUNK_BYTES-1:0]      chunk_mark,
    input  logic [OFS_W-1:0]            entry_ofs,
    input  logic                        redirect,
    output logic [NSLOT-1:0]            slot_vld,
    output logic [NSLOT*OFS_W-1:0]      slot_start,
    output logic [NSLOT*LEN_W-1:0]      slot_len,
    output logic [CNT_W-1:0]            pre_cnt,
    output logic [MAX_LEN*8-1:0]        pre_data,
    output logic                        entry_bad,
    output logic                        len_overrun,
    output logic                        refetch,
    output logic [OFS_W-1:0]            refetch_ofs
);

    ofs_t               s_base;
    cnt_t               used_cnt;
    logic               bad_raw;
    logic               emit;
    logic [NSLOT-1:0]   hit;
    ofs_t [NSLOT-1:0]   end_pos;
    logic               more;
    logic               any_end;
    ofs_t               last_end;
    slot_t [NSLOT-1:0]  slots;

    carry_op_e          c_op;
    cnt_t               c_keep;
    len_t               c_tail;
    cnt_t               c_cnt;
    logic [MAX_LEN*8-1:0] c_data;
    logic               c_over;

    assign s_base   = redirect ? entry_ofs : '0;
    assign used_cnt = (chunk_vld && !redirect) ? c_cnt : '0;

    ibx_entry_chk u_entry (
        .redirect (redirect),
        .entry    (entry_ofs),
        .mark     (chunk_mark),
        .bad      (bad_raw)
    );

    ibx_end_scan u_scan (
        .base     (s_base),
        .mark     (chunk_mark),
        .hit      (hit),
        .pos      (end_pos),
        .more     (more),
        .any_end  (any_end),
        .last_end (last_end)
    );

    assign entry_bad = chunk_vld && bad_raw;
    assign emit      = chunk_vld && !bad_raw;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        ofs_t st_k;
        len_t ln_k;
        if (k == 0) begin : g_first
            assign st_k = s_base;
            assign ln_k = len_t'(end_pos[k]) - len_t'(st_k) + len_t'(1)
                        + len_t'(used_cnt);
        end else begin : g_next
            assign st_k = end_pos[k-1] + 1'b1;
            assign ln_k = len_t'(end_pos[k]) - len_t'(st_k) + len_t'(1);
        end
        assign slots[k].vld   = emit && hit[k];
        assign slots[k].start = slots[k].vld ? st_k : '0;
        assign slots[k].len   = slots[k].vld ? ln_k : '0;

        assign slot_vld[k]                   = slots[k].vld;
        assign slot_start[k*OFS_W +: OFS_W]  = slots[k].start;
        assign slot_len[k*LEN_W +: LEN_W]    = slots[k].len;
    end

    assign refetch     = emit && more;
    assign refetch_ofs = refetch ? (end_pos[NSLOT-1] + 1'b1) : '0;

    always_comb begin
        c_op   = CARRY_KEEP;
        c_keep = '0;
        c_tail = len_t'(s_base);
        if (chunk_vld) begin
            if (bad_raw || more) begin
                c_op = CARRY_CLEAR;
            end else begin
                c_op = CARRY_LOAD;
                if (any_end) begin
                    c_tail = len_t'(last_end) + len_t'(1);
                end else begin
                    c_keep = used_cnt;
                end
            end
        end
    end

    ibx_carry_buf u_carry (
        .clk      (clk),
        .rst      (rst),
        .op       (c_op),
        .keep_cnt (c_keep),
        .tail     (c_tail),
        .chunk    (chunk_data),
        .cnt      (c_cnt),
        .data     (c_data),
        .overrun  (c_over)
    );

    assign len_overrun = c_over;
    assign pre_cnt     = used_cnt;
    assign pre_data    = (chunk_vld && !redirect) ? c_data : '0;

endmodule

// File: rtl/ibx_extract_chk.sv
module ibx_extract_chk
    import ibx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chunk_vld,
    input  logic [CHUNK_BYTES-1:0]      chunk_mark,
    input  logic [OFS_W-1:0]            entry_ofs,
    input  logic                        redirect,
    input  logic [NSLOT-1:0]            slot_vld,
    input  logic [NSLOT*OFS_W-1:0]      slot_start,
    input  logic [NSLOT*LEN_W-1:0]      slot_len,
    input  logic [CNT_W-1:0]            pre_cnt,
    input  logic                        entry_bad,
    input  logic                        len_overrun,
    input  logic                        refetch
);

    ofs_t st [NSLOT];
    len_t ln [NSLOT];
    ofs_t eb [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
        assign st[k] = slot_start[k*OFS_W +: OFS_W];
        assign ln[k] = slot_len[k*LEN_W +: LEN_W];
        assign eb[k] = ofs_t'(len_t'(st[k]) + ln[k] - len_t'(1));
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !chunk_vld |-> (slot_vld == '0) && !entry_bad && !len_overrun && !refetch); // R10

    AST_BAD_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        entry_bad |-> (slot_vld == '0) && !refetch && redirect && (entry_ofs != '0)); // R4

    AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        entry_bad |=> (pre_cnt == '0)); // R4

    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (rst)
        ((slot_vld + 1'b1) & slot_vld) == '0); // R2

    AST_REFETCH_FULL: assert property (@(posedge clk) disable iff (rst)
        refetch |-> (&slot_vld)); // R9

    AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        len_overrun |=> (pre_cnt == '0)); // R7

    AST_REDIRECT_BASE: assert property (@(posedge clk) disable iff (rst)
        (slot_vld[0] && redirect) |-> (st[0] == entry_ofs)); // R3

    for (genvar k = 1; k < NSLOT; k++) begin : g_chain
        AST_SLOT_ENDS_MARKED: assert property (@(posedge clk) disable iff (rst)
            slot_vld[k] |-> chunk_mark[eb[k]]); // R2

        AST_SLOT_ABUTS: assert property (@(posedge clk) disable iff (rst)
            slot_vld[k] |-> (len_t'(st[k]) == len_t'(st[k-1]) + ln[k-1]
                             - ((k == 1) ? len_t'(pre_cnt) : len_t'(0)))); // R5
    end

endmodule

bind ibx_extract ibx_extract_chk u_chk (.*);

// File: tb/ibx_extract_bench.sv
`timescale 1ns/1ps
module ibx_extract_bench;

    localparam real PERIOD = 8.0;

    logic          clk = 1'b0;
    logic          rst;
    logic          chunk_vld;
    logic [127:0]  chunk_data;
    logic [15:0]   chunk_mark;
    logic [3:0]    entry_ofs;
    logic          redirect;
    logic [3:0]    slot_vld;
    logic [15:0]   slot_start;
    logic [19:0]   slot_len;
    logic [3:0]    pre_cnt;
    logic [119:0]  pre_data;
    logic          entry_bad;
    logic          len_overrun;
    logic          refetch;
    logic [3:0]    refetch_ofs;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  prev_noend = 1'b0;
    logic [7:0] q[$];

    always #(PERIOD/2) clk = ~clk;

    ibx_extract u_ibx_extract (
        .clk(clk), .rst(rst), .chunk_vld(chunk_vld), .chunk_data(chunk_data),
        .chunk_mark(chunk_mark), .entry_ofs(entry_ofs), .redirect(redirect),
        .slot_vld(slot_vld), .slot_start(slot_start), .slot_len(slot_len),
        .pre_cnt(pre_cnt), .pre_data(pre_data), .entry_bad(entry_bad),
        .len_overrun(len_overrun), .refetch(refetch), .refetch_ofs(refetch_ofs)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_check(input bit v, input logic [127:0] d, input logic [15:0] m,
                               input int e, input bit r);
        int s;
        int used;
        bit bad;
        int ends[$];
        int n;
        logic [7:0] nq[$];
        bit ov;
        bit rf;
        string ptag;
        s    = r ? e : 0;
        used = (v && !r) ? q.size() : 0;
        ptag = !v ? "R10" : (r ? "R8" : (prev_noend ? "R6" : "R5"));
        chk(ptag, "pre_cnt", int'(pre_cnt), used);
        for (int i = 0; i < used; i++) chk("R5", "pre_data", int'(pre_data[8*i +: 8]), int'(q[i]));
        if (!v) begin
            chk("R10", "slot_vld", int'(slot_vld), 0);
            chk("R10", "entry_bad", int'(entry_bad), 0);
            chk("R10", "len_overrun", int'(len_overrun), 0);
            chk("R10", "refetch", int'(refetch), 0);
            return;
        end
        prev_noend = 1'b0;
        if (r) q.delete();
        bad = r && (e != 0) && !m[e-1];
        chk("R4", "entry_bad", int'(entry_bad), int'(bad));
        if (bad) begin
            chk("R4", "slot_vld", int'(slot_vld), 0);
            chk("R4", "refetch", int'(refetch), 0);
            q.delete();
            return;
        end
        for (int p = s; p < 16; p++) if (m[p]) ends.push_back(p);
        n = ends.size();
        chk(r ? "R3" : "R2", "slot_vld", int'(slot_vld), (1 << (n > 4 ? 4 : n)) - 1);
        for (int k = 0; k < (n > 4 ? 4 : n); k++) begin
            int st;
            int ln;
            string t;
            st = (k == 0) ? s : ends[k-1] + 1;
            ln = ends[k] - st + 1 + ((k == 0) ? used : 0);
            t  = (k == 0 && used > 0) ? "R5" : ((k == 0 && r) ? "R3" : "R2");
            chk(t, "slot_start", int'(slot_start[4*k +: 4]), st);
            chk(t, "slot_len", int'(slot_len[5*k +: 5]), ln);
        end
        rf = n > 4;
        chk("R9", "refetch", int'(refetch), int'(rf));
        if (rf) chk("R9", "refetch_ofs", int'(refetch_ofs), ends[3] + 1);
        ov = 1'b0;
        if (rf) begin
            q.delete();
        end else begin
            if (n == 0) begin
                nq = q;
                for (int p = s; p < 16; p++) nq.push_back(d[8*p +: 8]);
                prev_noend = 1'b1;
            end else begin
                for (int p = ends[n-1] + 1; p < 16; p++) nq.push_back(d[8*p +: 8]);
            end
            if (nq.size() > 15) begin
                ov = 1'b1;
                q.delete();
                prev_noend = 1'b0;
            end else begin
                q = nq;
            end
        end
        chk(ov ? "R7" : (n == 0 ? "R6" : "R5"), "len_overrun", int'(len_overrun), int'(ov));
    endtask

    task automatic cyc(input bit v, input logic [127:0] d, input logic [15:0] m,
                       input int e, input bit r);
        @(negedge clk);
        chunk_vld  = v;
        chunk_data = d;
        chunk_mark = m;
        entry_ofs  = 4'(e);
        redirect   = r;
        #1;
        model_check(v, d, m, e, r);
    endtask

    function automatic logic [127:0] rnd_data();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [15:0] rnd_marks();
        logic [15:0] mk;
        int pos;
        mk  = '0;
        pos = $urandom_range(0, 5);
        while (pos < 16) begin
            mk[pos] = 1'b1;
            pos += $urandom_range(1, 7);
        end
        return mk;
    endfunction

    initial begin
        rst = 1'b1; chunk_vld = 0; chunk_data = '0; chunk_mark = '0;
        entry_ofs = '0; redirect = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "slot_vld in reset", int'(slot_vld), 0);
        chk("R1", "pre_cnt in reset", int'(pre_cnt), 0);
        rst = 1'b0;
        // R1: first sequential chunk after reset carries nothing
        cyc(1, rnd_data(), 16'h0204, 0, 0);
        // R2/R5: three ends and a 6-byte tail, then joined to next chunk
        cyc(1, rnd_data(), 16'h0224, 0, 0);
        cyc(1, rnd_data(), 16'h8002, 0, 0);
        // R10: carry held across idle cycles
        cyc(1, rnd_data(), 16'h0010, 0, 0);
        cyc(0, rnd_data(), 16'hFFFF, 3, 1);
        cyc(0, rnd_data(), 16'h0000, 0, 0);
        cyc(1, rnd_data(), 16'h0100, 9, 0);
        // R3: entry at last byte with previous byte flagged
        cyc(1, rnd_data(), 16'hC000, 15, 1);
        // R3: entry_ofs ignored on a sequential chunk
        cyc(1, rnd_data(), 16'h0081, 12, 0);
        // R4: entry lands in the middle of an instruction
        cyc(1, rnd_data(), 16'h0020, 0, 0);
        cyc(1, rnd_data(), 16'h0300, 7, 1);
        cyc(1, rnd_data(), 16'h0001, 0, 0);
        // R4: redirect to byte 0 is never flagged
        cyc(1, rnd_data(), 16'h0000, 0, 1);
        // R6 then R7: redirected chunk without an end, then a sequential one
        cyc(1, rnd_data(), 16'h0200, 10, 1);
        cyc(1, rnd_data(), 16'h0000, 0, 0);
        cyc(1, rnd_data(), 16'h0000, 0, 0);
        // R8: carry exists, redirect drops it
        cyc(1, rnd_data(), 16'h0008, 0, 0);
        cyc(1, rnd_data(), 16'h0104, 0, 1);
        cyc(1, rnd_data(), 16'h0400, 0, 0);
        // R9: every byte flagged, walk with refetch offsets
        cyc(1, rnd_data(), 16'hFFFF, 0, 0);
        cyc(1, rnd_data(), 16'hFFFF, 4, 1);
        cyc(1, rnd_data(), 16'hFFFF, 8, 1);
        cyc(1, rnd_data(), 16'hFFFF, 12, 1);
        // R1: reset in mid-stream discards the carry
        cyc(1, rnd_data(), 16'h0001, 0, 0);
        @(negedge clk); rst = 1'b1; chunk_vld = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        q.delete(); prev_noend = 1'b0;
        chunk_vld = 1; chunk_data = rnd_data(); chunk_mark = 16'h8000;
        entry_ofs = 0; redirect = 0;
        #1;
        chk("R1", "pre_cnt after reset", int'(pre_cnt), 0);
        model_check(1, chunk_data, chunk_mark, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit v;
            bit r;
            logic [15:0] mk;
            v  = ($urandom_range(0, 9) != 0);
            r  = ($urandom_range(0, 4) == 0);
            mk = ($urandom_range(0, 7) == 0) ? 16'(($urandom_range(0, 3) == 0) ? 0 : $urandom)
                                             : rnd_marks();
            cyc(v, rnd_data(), mk, $urandom_range(0, 15), r);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule